// File: doc/BRIEF.md
# Instruction Control Decoder

This block is the purely combinational decode stage of a small accumulator-style processor that uses 16-bit instructions. It looks only at the upper byte of the instruction, the operation byte, and turns it into one control word for the datapath. That word holds the write enables for registers A and B, a 2-bit code that selects the single driver of the B-bus, the memory address source, the memory write strobe, the ALU operation, a flag-capture enable and the kind and condition of a jump.

The operand byte does not pass through this block; the datapath gets it directly. The decoder also checks that the operation byte is legal. The opcode decides which addressing modes may be used, and it also decides what each mode means. If the combination is not allowed, or a reserved bit is set, the decoder raises an illegal flag. In that case every other output is forced to zero, so no register, memory location or program counter can be disturbed.

The decoder sits between the instruction register and the datapath. Its outputs settle in the same cycle as its input, and it holds no state. The only interface is a plain operation-byte input. There is no valid/ready handshake, because nothing is queued and nothing can apply back-pressure.

Top module: `opdec_top`

## Requirements
- R1: The opcode is bits 2..0 (0 load, 1 store, 2 add, 3 sub, 4 jump, 5 jump-if-zero, 6 jump-if-carry, 7 nop). `alu_op` is 1 for add, 2 for sub and 0 (pass) for every other legal byte.
- R2: For legal load, add and sub, bit 3 chooses the destination: 0 sets only `wr_a` and 1 sets only `wr_b`. No other byte sets either enable, and both are never high together.
- R3: `bsrc` values are 0 operand, 1 memory data, 2 register A, 3 register B. Addressing mode is bits 5..4 (0 immediate or PC-relative, 1 direct, 2 indirect through B, 3 register). Loads, adds and subs pick 0 in mode 0 and 1 in modes 1 and 2. In mode 3, a load picks the register opposite the target and an add or sub picks register B. A store picks its target register (A gives 2, B gives 3). Jump and nop bytes give 0.
- R4: `addr_sel` is 1 (address from register B) only for legal load, store, add or sub in mode 2. Otherwise it is 0 (address from the operand). `mem_we` is 1 only for a legal store.
- R5: `flag_we` is 1 only for legal add and sub.
- R6: For jump opcodes, `jmp_type` is 1 (PC plus operand plus one) in mode 0, 2 (operand) in mode 1 and 3 (register B) in mode 2. `jmp_cond` is 0 always, 1 zero flag, 2 carry flag, for jump, jump-if-zero and jump-if-carry in that order. Bit 3 has no effect, and jumps assert no write enable. Non-jump bytes give `jmp_type` 0 and `jmp_cond` 0.
- R7: Nop with bits 7..6 at zero is legal in every mode and with either target, and drives every output to zero.
- R8: If bits 7..6 are nonzero, or a store uses mode 0 or 3, or a jump opcode uses mode 3, then `illegal` is 1 and all other outputs are 0.
- R9: Every other byte value gives `illegal` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_byte | input | OP_W | Operation byte of the current instruction |
| wr_a | output | 1 | Write enable for register A |
| wr_b | output | 1 | Write enable for register B |
| bsrc | output | 2 | Encoded B-bus source |
| addr_sel | output | 1 | Memory address source: 0 operand, 1 register B |
| mem_we | output | 1 | Data memory write strobe |
| alu_op | output | 2 | ALU function: 0 pass, 1 add, 2 subtract |
| flag_we | output | 1 | Capture zero and carry flags |
| jmp_type | output | 2 | Jump target kind: 0 none, 1 relative, 2 operand, 3 register B |
| jmp_cond | output | 2 | Jump condition: 0 always, 1 zero, 2 carry |
| illegal | output | 1 | Operation byte is not a legal encoding |

## Verification
The bench builds the decoder with the default operation-byte width of 8. At that width the input space has only 256 values, so a sweep can compare all of them against a model written from the requirements. That sweep reaches every legal and illegal pairing of opcode, mode, target bit and reserved bits. Directed tasks run before the sweep and look at the cases that matter most, one at a time: source selection that depends on the target, indirect addressing, relative jumps that ignore the target bit, and the complete silencing of illegal bytes.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

  localparam int OPC_W  = 3;
  localparam int MODE_W = 2;
  localparam int NOPC   = 1 << OPC_W;
  localparam int NMODE  = 1 << MODE_W;

  typedef enum logic [OPC_W-1:0] {
    OPC_LOAD  = 3'd0,
    OPC_STORE = 3'd1,
    OPC_ADD   = 3'd2,
    OPC_SUB   = 3'd3,
    OPC_JMP   = 3'd4,
    OPC_JZ    = 3'd5,
    OPC_JC    = 3'd6,
    OPC_NOP   = 3'd7
  } opc_e;

  typedef enum logic [MODE_W-1:0] {
    AM_IMM = 2'd0,
    AM_DIR = 2'd1,
    AM_IND = 2'd2,
    AM_REG = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    BS_OPND = 2'd0,
    BS_MEM  = 2'd1,
    BS_REGA = 2'd2,
    BS_REGB = 2'd3
  } bsrc_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2
  } alu_e;

  typedef enum logic [1:0] {
    JT_NONE = 2'd0,
    JT_REL  = 2'd1,
    JT_OPND = 2'd2,
    JT_REGB = 2'd3
  } jtype_e;

  typedef enum logic [1:0] {
    JC_ALWAYS = 2'd0,
    JC_ZERO   = 2'd1,
    JC_CARRY  = 2'd2
  } jcond_e;

  typedef struct packed {
    logic   wr_a;
    logic   wr_b;
    bsrc_e  bsrc;
    logic   addr_sel;
    logic   mem_we;
    alu_e   alu_op;
    logic   flag_we;
    jtype_e jmp_type;
    jcond_e jmp_cond;
  } ctl_word_t;

  // Bit m of the result is set when addressing mode m is allowed for opc.
  function automatic logic [NMODE-1:0] mode_mask(input logic [OPC_W-1:0] opc);
    logic [NMODE-1:0] m;
    case (opc)
      OPC_LOAD, OPC_ADD, OPC_SUB: m = 4'b1111;
      OPC_STORE:                  m = 4'b0110;
      OPC_JMP, OPC_JZ, OPC_JC:    m = 4'b0111;
      default:                    m = 4'b1111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/opdec_fields.sv
module opdec_fields
  import opdec_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] op_byte,
  output opc_e            opc,
  output logic            tgt_b,
  output amode_e          mode,
  output logic            ext_nz
);
  localparam int TGT_POS  = OPC_W;
  localparam int MODE_LSB = OPC_W + 1;
  localparam int EXT_LSB  = MODE_LSB + MODE_W;

  assign opc    = opc_e'(op_byte[OPC_W-1:0]);
  assign tgt_b  = op_byte[TGT_POS];
  assign mode   = amode_e'(op_byte[MODE_LSB +: MODE_W]);
  assign ext_nz = |op_byte[OP_W-1:EXT_LSB];
endmodule

// File: rtl/opdec_legal.sv
module opdec_legal
  import opdec_pkg::*;
(
  input  opc_e   opc,
  input  amode_e mode,
  input  logic   ext_nz,
  output logic   illegal
);
  logic [NOPC-1:0] row_ok;

  for (genvar g = 0; g < NOPC; g++) begin : g_row
    localparam logic [NMODE-1:0] MASK = mode_mask(OPC_W'(g));
    assign row_ok[g] = MASK[mode];
  end

  assign illegal = ext_nz | ~row_ok[opc];
endmodule

// File: rtl/opdec_word.sv
module opdec_word
  import opdec_pkg::*;
(
  input  opc_e      opc,
  input  logic      tgt_b,
  input  amode_e    mode,
  output ctl_word_t word
);
  bsrc_e data_src;
  bsrc_e reg_src;

  // Operand-side source shared by load, add and sub.
  always_comb begin
    case (mode)
      AM_IMM:  data_src = BS_OPND;
      AM_DIR,
      AM_IND:  data_src = BS_MEM;
      default: data_src = reg_src;
    endcase
  end

  // Register mode: load takes the opposite register, arithmetic takes B.
  assign reg_src = (opc == OPC_LOAD) ? (tgt_b ? BS_REGA : BS_REGB) : BS_REGB;

  always_comb begin
    word = '0;
    case (opc)
      OPC_LOAD, OPC_ADD, OPC_SUB: begin
        word.wr_a     = ~tgt_b;
        word.wr_b     = tgt_b;
        word.bsrc     = data_src;
        word.addr_sel = (mode == AM_IND);
        word.flag_we  = (opc != OPC_LOAD);
        word.alu_op   = (opc == OPC_ADD) ? ALU_ADD :
                        (opc == OPC_SUB) ? ALU_SUB : ALU_PASS;
      end
      OPC_STORE: begin
        word.mem_we   = 1'b1;
        word.bsrc     = tgt_b ? BS_REGB : BS_REGA;
        word.addr_sel = (mode == AM_IND);
      end
      OPC_JMP, OPC_JZ, OPC_JC: begin
        word.jmp_type = (mode == AM_IMM) ? JT_REL :
                        (mode == AM_DIR) ? JT_OPND : JT_REGB;
        word.jmp_cond = (opc == OPC_JZ) ? JC_ZERO :
                        (opc == OPC_JC) ? JC_CARRY : JC_ALWAYS;
      end
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/opdec_top.sv
module opdec_top
  import opdec_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] op_byte,
  output logic            wr_a,
  output logic            wr_b,
  output logic [1:0]      bsrc,
  output logic            addr_sel,
  output logic            mem_we,
  output logic [1:0]      alu_op,
  output logic            flag_we,
  output logic [1:0]      jmp_type,
  output logic [1:0]      jmp_cond,
  output logic            illegal
);
  opc_e      opc;
  amode_e    mode;
  logic      tgt_b;
  logic      ext_nz;
  ctl_word_t raw;
  ctl_word_t gated;

  opdec_fields #(.OP_W(OP_W)) u_fields (
    .op_byte (op_byte),
    .opc     (opc),
    .tgt_b   (tgt_b),
    .mode    (mode),
    .ext_nz  (ext_nz)
  );

  opdec_legal u_legal (
    .opc     (opc),
    .mode    (mode),
    .ext_nz  (ext_nz),
    .illegal (illegal)
  );

  opdec_word u_word (
    .opc   (opc),
    .tgt_b (tgt_b),
    .mode  (mode),
    .word  (raw)
  );

  // An illegal byte silences the whole control word.
  assign gated = illegal ? '0 : raw;

  assign wr_a     = gated.wr_a;
  assign wr_b     = gated.wr_b;
  assign bsrc     = gated.bsrc;
  assign addr_sel = gated.addr_sel;
  assign mem_we   = gated.mem_we;
  assign alu_op   = gated.alu_op;
  assign flag_we  = gated.flag_we;
  assign jmp_type = gated.jmp_type;
  assign jmp_cond = gated.jmp_cond;
endmodule

// File: rtl/opdec_checker.sv
module opdec_checker #(
  parameter int OP_W = 8
) (
  input logic [OP_W-1:0] op_byte,
  input logic            wr_a,
  input logic            wr_b,
  input logic [1:0]      bsrc,
  input logic            addr_sel,
  input logic            mem_we,
  input logic [1:0]      alu_op,
  input logic            flag_we,
  input logic [1:0]      jmp_type,
  input logic [1:0]      jmp_cond,
  input logic            illegal
);
  always_comb begin
    assert_single_dest_R2: assert (!(wr_a && wr_b))
      else $error("both register enables high");
    assert_flag_arith_R5: assert (!flag_we || alu_op == 2'd1 || alu_op == 2'd2)
      else $error("flag capture without arithmetic");
    assert_store_only_R4: assert (!mem_we || (!wr_a && !wr_b && jmp_type == 2'd0))
      else $error("memory write combined with other action");
    assert_jump_quiet_R6: assert (jmp_type == 2'd0 || (!wr_a && !wr_b && !mem_we && !flag_we))
      else $error("jump with a write enable");
    assert_ext_bits_R8: assert (op_byte[OP_W-1:6] == '0 || illegal)
      else $error("reserved bits set but accepted");
    assert_illegal_silent_R8: assert (!illegal ||
        {wr_a, wr_b, bsrc, addr_sel, mem_we, alu_op, flag_we, jmp_type, jmp_cond} == '0)
      else $error("illegal byte drives control");
  end
endmodule

bind opdec_top opdec_checker #(.OP_W(OP_W)) u_opdec_checker (.*);

// File: tb/opdec_top_test.sv
`timescale 1ns/1ps
module opdec_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] op_byte = 8'h00;
  logic       wr_a, wr_b, addr_sel, mem_we, flag_we, illegal;
  logic [1:0] bsrc, alu_op, jmp_type, jmp_cond;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  opdec_top #(.OP_W(8)) uut (
    .op_byte (op_byte), .wr_a (wr_a), .wr_b (wr_b), .bsrc (bsrc),
    .addr_sel (addr_sel), .mem_we (mem_we), .alu_op (alu_op),
    .flag_we (flag_we), .jmp_type (jmp_type), .jmp_cond (jmp_cond),
    .illegal (illegal)
  );

  // Packed order: wr_a wr_b bsrc addr_sel mem_we alu_op flag_we jmp_type jmp_cond illegal
  function automatic logic [13:0] model(input logic [7:0] op);
    logic [2:0] opc = op[2:0];
    logic       t = op[3];
    logic [1:0] m = op[5:4];
    logic a = 0, b = 0, as = 0, we = 0, fw = 0;
    logic [1:0] bs = 0, al = 0, jt = 0, jc = 0;
    bit bad;
    bad = (op[7:6] != 0) || (opc == 3'd1 && (m == 0 || m == 3)) ||
          (opc >= 3'd4 && opc <= 3'd6 && m == 3);
    if (bad) return 14'b1;
    if (opc == 0 || opc == 2 || opc == 3) begin
      a = !t; b = t; as = (m == 2); fw = (opc != 0);
      al = (opc == 2) ? 2'd1 : (opc == 3) ? 2'd2 : 2'd0;
      if (m == 0) bs = 0;
      else if (m != 3) bs = 1;
      else if (opc == 0) bs = t ? 2'd2 : 2'd3;
      else bs = 3;
    end else if (opc == 1) begin
      we = 1; bs = t ? 2'd3 : 2'd2; as = (m == 2);
    end else if (opc != 7) begin
      jt = (m == 0) ? 2'd1 : (m == 1) ? 2'd2 : 2'd3;
      jc = 2'(opc - 3'd4);
    end
    return {a, b, bs, as, we, al, fw, jt, jc, 1'b0};
  endfunction

  function automatic logic [13:0] observed();
    return {wr_a, wr_b, bsrc, addr_sel, mem_we, alu_op, flag_we, jmp_type, jmp_cond, illegal};
  endfunction

  task automatic apply(input logic [7:0] op, input string req);
    logic [13:0] exp_w;
    @(negedge clk);
    op_byte = op;
    #1;
    exp_w = model(op);
    n_vec++;
    if (observed() !== exp_w) begin
      n_bad++;
      $display("FAIL %s op=%08b actual=%014b expected=%014b", req, op, observed(), exp_w);
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    #1;
    n_vec++;
    if (!(wr_a && !wr_b && bsrc == 2'd0 && !illegal)) begin
      n_bad++;
      $display("FAIL R2 initial actual=%014b expected=%014b", observed(), model(8'h00));
    end
  endtask

  task automatic t_alu_ops();   // R1
    apply(8'b0000_0010, "R1");
    apply(8'b0001_0011, "R1");
    apply(8'b0011_0000, "R1");
  endtask

  task automatic t_targets();   // R2
    apply(8'b0000_0000, "R2");
    apply(8'b0000_1000, "R2");
    apply(8'b0010_1011, "R2");
  endtask

  task automatic t_bus_sources();   // R3
    apply(8'b0011_0000, "R3");  // load A,B -> reg B
    apply(8'b0011_1000, "R3");  // load B,A -> reg A
    apply(8'b0011_1010, "R3");  // add B,B -> reg B
    apply(8'b0001_1001, "R3");  // store B direct
    apply(8'b0010_0001, "R3");  // store A indirect
  endtask

  task automatic t_memory();   // R4
    apply(8'b0010_0000, "R4");
    apply(8'b0001_0000, "R4");
    apply(8'b0010_1001, "R4");
  endtask

  task automatic t_flags();   // R5
    apply(8'b0000_0011, "R5");
    apply(8'b0001_1000, "R5");
  endtask

  task automatic t_jumps();   // R6
    apply(8'b0000_0100, "R6");
    apply(8'b0000_1100, "R6");  // target bit ignored
    apply(8'b0001_0101, "R6");
    apply(8'b0010_0110, "R6");
    apply(8'b0010_1110, "R6");
  endtask

  task automatic t_nop();   // R7
    apply(8'b0000_0111, "R7");
    apply(8'b0011_1111, "R7");
  endtask

  task automatic t_illegal();   // R8
    apply(8'b0100_0000, "R8");
    apply(8'b1000_0010, "R8");
    apply(8'b0000_0001, "R8");
    apply(8'b0011_1001, "R8");
    apply(8'b0011_0100, "R8");
    apply(8'b0011_1110, "R8");
  endtask

  task automatic t_sweep();   // R9 and all others, exhaustive
    for (int v = 0; v < 256; v++) apply(8'(v), "R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_alu_ops();
    t_targets();
    t_bus_sources();
    t_memory();
    t_flags();
    t_jumps();
    t_nop();
    t_illegal();
    t_sweep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule